// File: doc/BRIEF.md
# Core Interrupt Event Selector

This block takes a 128-bit vector of one-cycle system event pulses and steers them onto twelve maskable processor interrupt lines and one exception line. Every incoming pulse sets a sticky flag. Software reads the flags and clears them through a small word-addressed register bus. Each interrupt line carries a programmable event number. When that event fires, the line gives a one-cycle pulse and sets its pending bit. The pending bit stays set until software acknowledges it.

Four event combiners each OR the unmasked flags of one 32-event group. The rising edge of each combiner's result re-enters the selector as event 0, 1, 2 or 3. If a line's event fires again while the line is still pending, the event is lost. The block records the line number and raises event 96 as an ordinary system event. The exception line is the OR of all flags enabled in a 128-bit exception mask.

Top module: `irq_event_selector`

## Requirements
- R1: Each interrupt line has a 7-bit event-number register. Lines 4 to 15 drive `int_o[0]` to `int_o[11]`, and their registers sit at word addresses 16 to 27. A read returns the number in bits [6:0].
- R2: When the selected event pulses, the line's `int_o` bit is high for exactly one cycle, starting at the clock edge that samples the pulse. Lines whose event did not fire stay low.
- R3: A line that fires sets its pending bit. The pending bits read at address 28, with bit j belonging to `int_o[j]`.
- R4: Writing 1 to a bit of address 28 clears that pending bit, and the next event on that line fires again.
- R5: An event that hits a still-pending line produces no pulse. It sets the drop record at address 29: bit 8 is valid and bits [3:0] hold the line number (4 to 15). Any write to address 29 clears the record to zero.
- R6: A drop raises event 96 for one cycle, on the cycle after the drop. When several lines drop at the same edge, the lowest line number is recorded.
- R7: Event flags are sticky. Word w (addresses 0 to 3) holds events 32w to 32w+31, with bit i = event 32w+i. Writing 1 to a bit clears that flag.
- R8: After reset, all flags, masks, maps, pending bits, the drop record, the outputs and the read data are zero.
- R9: The external inputs at positions 0 to 3 and 96 are ignored. Those event numbers come only from the combiners and from drop detection.
- R10: `exc_o` goes high one cycle after a flag that is enabled in the exception mask (addresses 8 to 11, same bit layout as the flags) becomes set. It goes low one cycle after that flag is cleared.
- R11: Combiner k uses the mask at address 4+k (bit 1 masks the flag). A newly set, unmasked flag in group k makes event k pulse once, two cycles after the input pulse. Masked flags have no effect.
- R12: If an acknowledge write and a new event for the same line arrive in the same cycle, the line fires and no drop is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 128 | System event pulses |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| int_o | output | 12 | Interrupt pulses for lines 4 to 15 |
| exc_o | output | 1 | Exception output |

## Verification
Results arrive at fixed delays after the clock edge that samples an event:
- A directly mapped line pulses at that edge.
- `exc_o` follows one edge later.
- A line mapped to a combiner event pulses two edges later.
- A line mapped to event 96 pulses one edge after the drop.
- Read data appears one edge after the read strobe.

The bench drives all inputs on the falling edge and samples on the following falling edges. Each check is placed at exactly the edge count above, and it also checks the quiet cycles just before. Ignored inputs and masked flags are checked by reading back the flag words and by watching `int_o` over the cycles in which a false pulse would have appeared.

// File: rtl/evsel_pkg.sv
package evsel_pkg;
  // Word addresses of the register regions
  localparam int A_FLAG  = 0;
  localparam int A_CMASK = 4;
  localparam int A_XMASK = 8;
  localparam int A_MAP   = 16;
  localparam int A_PEND  = 28;
  localparam int A_DROP  = 29;
  // Bit position of the valid flag in the drop record
  localparam int DROP_VALID_BIT = 8;
endpackage

// File: rtl/evsel_flags.sv
module evsel_flags #(
  parameter int N_EVT  = 128,
  parameter int WORD_W = 32,
  localparam int N_WORDS = N_EVT / WORD_W,
  localparam int WSEL_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  set_i,
  input  logic              clr_en_i,
  input  logic [WSEL_W-1:0] clr_sel_i,
  input  logic [WORD_W-1:0] clr_bits_i,
  output logic [N_EVT-1:0]  flag_o
);
  logic [N_EVT-1:0] flag_q;
  logic [N_EVT-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    if (clr_en_i) clr_vec[clr_sel_i*WORD_W +: WORD_W] = clr_bits_i;
  end

  // A set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~clr_vec) | set_i;
  end

  assign flag_o = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr_en_i |=> (($past(flag_q) & ~flag_q) == '0)) else $error("flag lost without clear"); // R7
endmodule

// File: rtl/evsel_combiner.sv
module evsel_combiner #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] flags_i,
  input  logic [WORD_W-1:0] mask_i,
  output logic              rise_o
);
  logic lvl_q;
  logic lvl_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= 1'b0;
      lvl_d_q <= 1'b0;
    end else begin
      lvl_q   <= |(flags_i & ~mask_i);
      lvl_d_q <= lvl_q;
    end
  end

  assign rise_o = lvl_q & ~lvl_d_q;

  AST_CMB_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o) else $error("combiner event longer than one cycle"); // R11
endmodule

// File: rtl/evsel_mapper.sv
module evsel_mapper #(
  parameter int N_EVT    = 128,
  parameter int N_OUT    = 12,
  parameter int OUT_BASE = 4,
  localparam int EVT_W  = $clog2(N_EVT),
  localparam int OIDX_W = $clog2(N_OUT),
  localparam int NUM_W  = $clog2(OUT_BASE + N_OUT)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_EVT-1:0]       evt_i,
  input  logic                   map_we_i,
  input  logic [OIDX_W-1:0]      map_idx_i,
  input  logic [EVT_W-1:0]       map_val_i,
  input  logic                   ack_en_i,
  input  logic [N_OUT-1:0]       ack_bits_i,
  input  logic                   drop_clr_i,
  output logic [N_OUT*EVT_W-1:0] map_flat_o,
  output logic [N_OUT-1:0]       pend_o,
  output logic [N_OUT-1:0]       int_o,
  output logic                   drop_valid_o,
  output logic [NUM_W-1:0]       drop_num_o,
  output logic                   drop_pulse_o
);
  logic [EVT_W-1:0] map_q [N_OUT];
  logic [N_OUT-1:0] hit, ack_vec, pend_keep, fire, lost;
  logic [N_OUT-1:0] pend_q, int_q;
  logic             drop_valid_q, drop_pulse_q;
  logic [NUM_W-1:0] drop_num_q, first_num;

  for (genvar j = 0; j < N_OUT; j++) begin : g_line
    assign hit[j] = evt_i[map_q[j]];
    assign map_flat_o[j*EVT_W +: EVT_W] = map_q[j];
  end

  always_comb begin
    ack_vec   = ack_en_i ? ack_bits_i : '0;
    pend_keep = pend_q & ~ack_vec;
    fire      = hit & ~pend_keep;
    lost      = hit & pend_keep;
    first_num = '0;
    for (int j = N_OUT - 1; j >= 0; j--)
      if (lost[j]) first_num = NUM_W'(j + OUT_BASE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < N_OUT; j++) map_q[j] <= '0;
    end else if (map_we_i) begin
      map_q[map_idx_i] <= map_val_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q       <= '0;
      int_q        <= '0;
      drop_pulse_q <= 1'b0;
      drop_valid_q <= 1'b0;
      drop_num_q   <= '0;
    end else begin
      int_q        <= fire;
      pend_q       <= pend_keep | fire;
      drop_pulse_q <= |lost;
      if (|lost) begin
        drop_valid_q <= 1'b1;
        drop_num_q   <= first_num;
      end else if (drop_clr_i) begin
        drop_valid_q <= 1'b0;
        drop_num_q   <= '0;
      end
    end
  end

  assign pend_o       = pend_q;
  assign int_o        = int_q;
  assign drop_valid_o = drop_valid_q;
  assign drop_num_o   = drop_num_q;
  assign drop_pulse_o = drop_pulse_q;

  AST_INT_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    (int_q & ~pend_q) == '0) else $error("pulse without pending bit"); // R3
  AST_INT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !ack_en_i |=> ((int_q & $past(int_q)) == '0)) else $error("pulse longer than one cycle"); // R2
  AST_DROP_RECORDED: assert property (@(posedge clk) disable iff (rst)
    drop_pulse_q |-> drop_valid_q) else $error("drop event without record"); // R5
  AST_DROP_NUM_RANGE: assert property (@(posedge clk) disable iff (rst)
    drop_valid_q |-> (drop_num_q >= NUM_W'(OUT_BASE))) else $error("drop line out of range"); // R5
endmodule

// File: rtl/irq_event_selector.sv
module irq_event_selector
  import evsel_pkg::*;
#(
  parameter int N_EVT    = 128,
  parameter int N_OUT    = 12,
  parameter int OUT_BASE = 4,
  parameter int N_CMB    = 4,
  parameter int WORD_W   = 32,
  parameter int DROP_EVT = 96,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [N_OUT-1:0]  int_o,
  output logic              exc_o
);
  localparam int N_WORDS = N_EVT / WORD_W;
  localparam int WSEL_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int CIDX_W  = (N_CMB > 1) ? $clog2(N_CMB) : 1;
  localparam int EVT_W   = $clog2(N_EVT);
  localparam int OIDX_W  = $clog2(N_OUT);
  localparam int NUM_W   = $clog2(OUT_BASE + N_OUT);

  int ai;
  assign ai = {{(32-ADDR_W){1'b0}}, addr_i};

  logic in_flag, in_cmask, in_xmask, in_map, at_pend, at_drop;
  assign in_flag  = (ai >= A_FLAG)  && (ai < A_FLAG + N_WORDS);
  assign in_cmask = (ai >= A_CMASK) && (ai < A_CMASK + N_CMB);
  assign in_xmask = (ai >= A_XMASK) && (ai < A_XMASK + N_WORDS);
  assign in_map   = (ai >= A_MAP)   && (ai < A_MAP + N_OUT);
  assign at_pend  = (ai == A_PEND);
  assign at_drop  = (ai == A_DROP);

  logic [WSEL_W-1:0] f_idx, x_idx;
  logic [CIDX_W-1:0] c_idx;
  logic [OIDX_W-1:0] m_idx;
  assign f_idx = WSEL_W'(ai - A_FLAG);
  assign x_idx = WSEL_W'(ai - A_XMASK);
  assign c_idx = CIDX_W'(ai - A_CMASK);
  assign m_idx = OIDX_W'(ai - A_MAP);

  logic [WORD_W-1:0]       cmask_q [N_CMB];
  logic [WORD_W-1:0]       xmask_q [N_WORDS];
  logic [N_EVT-1:0]        xmask_flat, flag, eff_evt;
  logic [N_CMB-1:0]        cmb_rise;
  logic [N_OUT*EVT_W-1:0]  map_flat;
  logic [N_OUT-1:0]        pend;
  logic                    drop_valid, drop_pulse, exc_q;
  logic [NUM_W-1:0]        drop_num;
  logic [WORD_W-1:0]       rd_val, rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_CMB; k++)   cmask_q[k] <= '0;
      for (int w = 0; w < N_WORDS; w++) xmask_q[w] <= '0;
    end else if (wr_en_i) begin
      if (in_cmask) cmask_q[c_idx] <= wdata_i;
      if (in_xmask) xmask_q[x_idx] <= wdata_i;
    end
  end

  for (genvar w = 0; w < N_WORDS; w++) begin : g_xm
    assign xmask_flat[w*WORD_W +: WORD_W] = xmask_q[w];
  end

  // Combiner and drop events replace the external inputs at their numbers
  always_comb begin
    eff_evt             = evt_i;
    eff_evt[N_CMB-1:0]  = cmb_rise;
    eff_evt[DROP_EVT]   = drop_pulse;
  end

  evsel_flags #(.N_EVT(N_EVT), .WORD_W(WORD_W)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .set_i      (eff_evt),
    .clr_en_i   (wr_en_i && in_flag),
    .clr_sel_i  (f_idx),
    .clr_bits_i (wdata_i),
    .flag_o     (flag)
  );

  for (genvar k = 0; k < N_CMB; k++) begin : g_cmb
    evsel_combiner #(.WORD_W(WORD_W)) u_cmb (
      .clk     (clk),
      .rst     (rst),
      .flags_i (flag[k*WORD_W +: WORD_W]),
      .mask_i  (cmask_q[k]),
      .rise_o  (cmb_rise[k])
    );
  end

  evsel_mapper #(.N_EVT(N_EVT), .N_OUT(N_OUT), .OUT_BASE(OUT_BASE)) u_map (
    .clk          (clk),
    .rst          (rst),
    .evt_i        (eff_evt),
    .map_we_i     (wr_en_i && in_map),
    .map_idx_i    (m_idx),
    .map_val_i    (wdata_i[EVT_W-1:0]),
    .ack_en_i     (wr_en_i && at_pend),
    .ack_bits_i   (wdata_i[N_OUT-1:0]),
    .drop_clr_i   (wr_en_i && at_drop),
    .map_flat_o   (map_flat),
    .pend_o       (pend),
    .int_o        (int_o),
    .drop_valid_o (drop_valid),
    .drop_num_o   (drop_num),
    .drop_pulse_o (drop_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) exc_q <= 1'b0;
    else     exc_q <= |(flag & xmask_flat);
  end
  assign exc_o = exc_q;

  always_comb begin
    rd_val = '0;
    if (in_flag)       rd_val = flag[f_idx*WORD_W +: WORD_W];
    else if (in_cmask) rd_val = cmask_q[c_idx];
    else if (in_xmask) rd_val = xmask_q[x_idx];
    else if (in_map)   rd_val[EVT_W-1:0] = map_flat[m_idx*EVT_W +: EVT_W];
    else if (at_pend)  rd_val[N_OUT-1:0] = pend;
    else if (at_drop) begin
      rd_val[NUM_W-1:0]     = drop_num;
      rd_val[DROP_VALID_BIT] = drop_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end
  assign rdata_o = rdata_q;

  AST_DROP_EVT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(flag[DROP_EVT]) |-> $past(drop_pulse)) else $error("event 96 set from outside"); // R9
endmodule

// File: tb/irq_event_selector_test.sv
module irq_event_selector_test;
  localparam int FLAG = 0, CMASK = 4, XMASK = 8, MAP = 16, PEND = 28, DROP = 29;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] evt = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [11:0]  int_o;
  logic         exc_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  irq_event_selector uut (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .int_o(int_o), .exc_o(exc_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_en = 1'b1; addr = 6'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input int e);
    evt[e] = 1'b1;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset();
    chk("R8 int_o after reset", 32'(int_o), 32'h0);
    chk("R8 exc_o after reset", 32'(exc_o), 32'h0);
    chk("R8 rdata after reset", rdata, 32'h0);
    rd(FLAG + 1, rv); chk("R8 flag word", rv, 32'h0);
    rd(PEND, rv);     chk("R8 pending", rv, 32'h0);
    rd(DROP, rv);     chk("R8 drop record", rv, 32'h0);
  endtask

  task automatic t_setup();
    for (int j = 0; j < 12; j++) wr(MAP + j, 32'd127);
    wr(CMASK + 0, 32'hFFFF_FFFF);
  endtask

  task automatic t_ignored();
    evt[2] = 1'b1; evt[96] = 1'b1;
    @(negedge clk);
    evt = '0;
    chk("R9 no pulse from ignored inputs", 32'(int_o), 32'h0);
    rd(FLAG + 0, rv); chk("R9 input 2 ignored", rv, 32'h0);
    rd(FLAG + 3, rv); chk("R9 input 96 ignored", rv, 32'h0);
  endtask

  task automatic t_map();
    wr(MAP + 0, 32'd37);
    rd(MAP + 0, rv); chk("R1 map readback", rv, 32'd37);
    pulse(37);
    chk("R2 line 4 pulse", 32'(int_o), 32'h001);
    @(negedge clk);
    chk("R2 pulse one cycle", 32'(int_o), 32'h000);
    rd(PEND, rv);     chk("R3 pending set", rv, 32'h001);
    rd(FLAG + 1, rv); chk("R7 flag 37 set", rv, 32'h20);
  endtask

  task automatic t_drop();
    wr(MAP + 11, 32'd96);
    pulse(37);
    chk("R5 no pulse while pending", 32'(int_o), 32'h000);
    @(negedge clk);
    chk("R6 event 96 reaches line 15", 32'(int_o), 32'h800);
    rd(DROP, rv);     chk("R5 drop record line 4", rv, 32'h104);
    rd(FLAG + 3, rv); chk("R6 flag 96 set", rv, 32'h1);
  endtask

  task automatic t_ack();
    wr(PEND, 32'h801);
    rd(PEND, rv); chk("R4 pending cleared", rv, 32'h0);
    pulse(37);
    chk("R4 fires after ack", 32'(int_o), 32'h001);
  endtask

  task automatic t_flags();
    wr(FLAG + 1, 32'h20);
    rd(FLAG + 1, rv); chk("R7 write-1 clears flag", rv, 32'h0);
  endtask

  task automatic t_exc();
    wr(XMASK + 2, 32'h40);
    pulse(70);
    chk("R10 exc not yet", 32'(exc_o), 32'h0);
    @(negedge clk);
    chk("R10 exc raised", 32'(exc_o), 32'h1);
    wr(FLAG + 2, 32'h40);
    chk("R10 exc held one more cycle", 32'(exc_o), 32'h1);
    @(negedge clk);
    chk("R10 exc cleared", 32'(exc_o), 32'h0);
  endtask

  task automatic t_combiner();
    logic [31:0] seen;
    wr(FLAG + 1, 32'hFFFF_FFFF);
    wr(CMASK + 1, ~(32'h1 << 10));
    wr(MAP + 1, 32'd1);
    repeat (3) @(negedge clk);
    pulse(43);
    seen = 32'(int_o);
    repeat (3) begin @(negedge clk); seen |= 32'(int_o); end
    chk("R11 masked flag no event", seen, 32'h0);
    pulse(42);
    seen = 32'(int_o);
    @(negedge clk);
    seen |= 32'(int_o);
    chk("R11 no early combiner event", seen, 32'h0);
    @(negedge clk);
    chk("R11 combiner event on line 5", 32'(int_o), 32'h002);
    @(negedge clk);
    chk("R11 combiner event single", 32'(int_o), 32'h000);
  endtask

  task automatic t_multi_drop();
    wr(DROP, 32'h0);
    wr(PEND, 32'h800);
    wr(MAP + 2, 32'd80);
    wr(MAP + 3, 32'd80);
    pulse(80);
    chk("R2 two lines share event", 32'(int_o), 32'h00C);
    @(negedge clk);
    pulse(80);
    chk("R5 both dropped", 32'(int_o), 32'h000);
    rd(DROP, rv); chk("R6 lowest line recorded", rv, 32'h106);
  endtask

  task automatic t_ack_same_cycle();
    wr(DROP, 32'h0);
    evt[37] = 1'b1; wr_en = 1'b1; addr = 6'(PEND); wdata = 32'h1;
    @(negedge clk);
    evt = '0; wr_en = 1'b0;
    chk("R12 fires with simultaneous ack", 32'(int_o), 32'h001);
    rd(DROP, rv); chk("R12 no drop", rv, 32'h0);
    rd(PEND, rv); chk("R12 still pending", rv & 32'h1, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_setup();
    t_ignored();
    t_map();
    t_drop();
    t_ack();
    t_flags();
    t_exc();
    t_combiner();
    t_multi_drop();
    t_ack_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule